// File: doc/BRIEF.md
# Hashed Address Signature Unit

This block holds a compact, fixed-width record of a set of memory addresses. Each stored address sets one bit in each of several equal-width fields, so the record is a superset encoding: an address that was never added may still appear to be present, but an address that was added never appears absent. Hardware that tracks which lines a speculative thread has read or written can keep one unit per access type. It then compares whole sets in one step instead of walking individual addresses.

An address is encoded in three steps. A fixed range of its bits is reversed in place, and every bit outside that range keeps its position. The low part of the result is cut into equal chunks starting at bit 0, and each chunk is decoded to a one-hot vector that sets one bit in its own field. Field 0 is fed from address bits the reversal never touches, so it acts as the cache set index, and the stored field 0 is an exact bitmask of the sets touched. The unit also gives combinational results for intersection and union with an operand signature, an emptiness flag for the stored record and for the intersection, and a test of whether one query address may be a member. A clear strobe wipes the record in one cycle.

Top module: `addrsig_unit`

## Requirements
- R1: After reset the stored signature is all zero, `sig_empty_o` is 1, `set_mask_o` is zero and `qry_hit_o` is 0.
- R2: An insert sets exactly one bit per field on the next rising edge. Field k occupies `sig_o[k*FIELD_W +: FIELD_W]` with FIELD_W = 2^CHUNK_W. The bit set in field k is the index equal to permuted-address bits `[k*CHUNK_W +: CHUNK_W]`.
- R3: The permutation reverses address bits PERM_LO..PERM_HI, so bit i moves to PERM_LO+PERM_HI-i, and leaves all other bits where they are. Permuted bits at or above N_CHUNKS*CHUNK_W are not hashed. With the defaults (16-bit address, two 6-bit chunks, range 6..13), address 0x1000 yields bits 0 and 66. Addresses 0x4000 and 0x0040 both yield bits 0 and 64.
- R4: Inserts accumulate. A bit once set stays set until a clear.
- R5: A signature counts as empty when at least one of its fields is all zero, even if other fields hold set bits. This applies both to `sig_empty_o` and to `and_empty_o`.
- R6: `qry_hit_o` is combinational and valid in the same cycle as `qry_addr_i`. It is 1 exactly when every bit of the query's encoding is set in the stored signature, which includes aliased addresses never inserted.
- R7: `and_o` is the bitwise AND of the stored signature and `opnd_i`, and `and_empty_o` applies the rule of R5 to it, in the same cycle.
- R8: `or_o` is the bitwise OR of the stored signature and `opnd_i`, in the same cycle.
- R9: `set_mask_o` equals field IDX_CHUNK (default 0) of the stored signature. That field is the exact OR of one-hot decodes of address bits `[CHUNK_W-1:0]` of every inserted address.
- R10: A clear strobe makes the whole stored signature zero on the next rising edge.
- R11: If a clear and an insert arrive in the same cycle, the clear wins and the inserted address leaves no trace.
- R12: With neither insert nor clear asserted, the stored signature does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear the stored signature |
| ins_vld_i | input | 1 | Insert strobe |
| ins_addr_i | input | ADDR_W | Address to insert |
| qry_addr_i | input | ADDR_W | Address for the membership test |
| opnd_i | input | SIG_W | Operand signature for intersection and union |
| sig_o | output | SIG_W | Stored signature |
| set_mask_o | output | FIELD_W | Exact cache-set bitmask (index field) |
| sig_empty_o | output | 1 | Stored signature is empty |
| qry_hit_o | output | 1 | Query address may be a member |
| and_o | output | SIG_W | Stored signature AND operand |
| and_empty_o | output | 1 | Intersection is empty |
| or_o | output | SIG_W | Stored signature OR operand |

## Verification
The whole state is visible on `sig_o`, so any wrong internal bit appears at the ports on the edge right after the faulty update. A wrongly set or lost bit also shows at once on `qry_hit_o`, `set_mask_o` and the emptiness flags, which depend on the register only through combinational logic. A fault in the permutation or chunk split only shows when an inserted address has bits inside the reversed range. The stimulus therefore uses single-bit addresses at the edges of that range, whose bit positions are worked out by hand. Clear priority is only visible when both strobes arrive in one cycle, so that case is driven on purpose.

// File: rtl/addrsig_pkg.sv
`timescale 1ns/1ps
package addrsig_pkg;
    localparam int unsigned DEF_ADDR_W    = 16;
    localparam int unsigned DEF_CHUNK_W   = 6;
    localparam int unsigned DEF_N_CHUNKS  = 2;
    localparam int unsigned DEF_PERM_LO   = 6;
    localparam int unsigned DEF_PERM_HI   = 13;
    localparam int unsigned DEF_IDX_CHUNK = 0;
endpackage

// File: rtl/addrsig_perm.sv
`timescale 1ns/1ps
// Fixed wiring permutation: reverse bits PERM_LO..PERM_HI, keep the rest.
module addrsig_perm #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned PERM_LO = 6,
    parameter int unsigned PERM_HI = 13
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] perm_o
);
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i >= PERM_LO && i <= PERM_HI) begin : g_rev
            assign perm_o[i] = addr_i[PERM_LO + PERM_HI - i];
        end else begin : g_keep
            assign perm_o[i] = addr_i[i];
        end
    end
endmodule

// File: rtl/addrsig_encode.sv
`timescale 1ns/1ps
// Turns one address into a signature with one bit set per field.
module addrsig_encode #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned CHUNK_W  = 6,
    parameter int unsigned N_CHUNKS = 2,
    parameter int unsigned PERM_LO  = 6,
    parameter int unsigned PERM_HI  = 13,
    localparam int unsigned FIELD_W = 1 << CHUNK_W,
    localparam int unsigned SIG_W   = N_CHUNKS * FIELD_W,
    localparam int unsigned HASH_W  = N_CHUNKS * CHUNK_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SIG_W-1:0]  code_o
);
    logic [ADDR_W-1:0] perm;

    addrsig_perm #(
        .ADDR_W (ADDR_W),
        .PERM_LO(PERM_LO),
        .PERM_HI(PERM_HI)
    ) u_perm (
        .addr_i(addr_i),
        .perm_o(perm)
    );

    for (genvar k = 0; k < N_CHUNKS; k++) begin : g_chunk
        logic [CHUNK_W-1:0] chunk;
        assign chunk = perm[k*CHUNK_W +: CHUNK_W];
        assign code_o[k*FIELD_W +: FIELD_W] = {{(FIELD_W-1){1'b0}}, 1'b1} << chunk;
    end

    if (ADDR_W > HASH_W) begin : g_spare
        logic unused_hi;
        assign unused_hi = ^perm[ADDR_W-1:HASH_W];
    end
endmodule

// File: rtl/addrsig_empty.sv
`timescale 1ns/1ps
// A signature is empty when any one of its fields holds no set bit.
module addrsig_empty #(
    parameter int unsigned CHUNK_W  = 6,
    parameter int unsigned N_CHUNKS = 2,
    localparam int unsigned FIELD_W = 1 << CHUNK_W,
    localparam int unsigned SIG_W   = N_CHUNKS * FIELD_W
) (
    input  logic [SIG_W-1:0] sig_i,
    output logic             empty_o
);
    logic [N_CHUNKS-1:0] field_zero;

    for (genvar k = 0; k < N_CHUNKS; k++) begin : g_field
        assign field_zero[k] = ~|sig_i[k*FIELD_W +: FIELD_W];
    end

    assign empty_o = |field_zero;
endmodule

// File: rtl/addrsig_unit.sv
`timescale 1ns/1ps
module addrsig_unit
    import addrsig_pkg::*;
#(
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned CHUNK_W   = DEF_CHUNK_W,
    parameter int unsigned N_CHUNKS  = DEF_N_CHUNKS,
    parameter int unsigned PERM_LO   = DEF_PERM_LO,
    parameter int unsigned PERM_HI   = DEF_PERM_HI,
    parameter int unsigned IDX_CHUNK = DEF_IDX_CHUNK,
    localparam int unsigned FIELD_W  = 1 << CHUNK_W,
    localparam int unsigned SIG_W    = N_CHUNKS * FIELD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              ins_vld_i,
    input  logic [ADDR_W-1:0] ins_addr_i,
    input  logic [ADDR_W-1:0] qry_addr_i,
    input  logic [SIG_W-1:0]  opnd_i,
    output logic [SIG_W-1:0]  sig_o,
    output logic [FIELD_W-1:0] set_mask_o,
    output logic              sig_empty_o,
    output logic              qry_hit_o,
    output logic [SIG_W-1:0]  and_o,
    output logic              and_empty_o,
    output logic [SIG_W-1:0]  or_o
);
    typedef struct packed {
        logic [SIG_W-1:0] sig;
    } state_t;

    state_t state_d, state_q;

    logic [SIG_W-1:0] ins_code;
    logic [SIG_W-1:0] qry_code;
    logic [SIG_W-1:0] qry_and;
    logic             qry_empty;

    addrsig_encode #(
        .ADDR_W  (ADDR_W),
        .CHUNK_W (CHUNK_W),
        .N_CHUNKS(N_CHUNKS),
        .PERM_LO (PERM_LO),
        .PERM_HI (PERM_HI)
    ) u_enc_ins (
        .addr_i(ins_addr_i),
        .code_o(ins_code)
    );

    addrsig_encode #(
        .ADDR_W  (ADDR_W),
        .CHUNK_W (CHUNK_W),
        .N_CHUNKS(N_CHUNKS),
        .PERM_LO (PERM_LO),
        .PERM_HI (PERM_HI)
    ) u_enc_qry (
        .addr_i(qry_addr_i),
        .code_o(qry_code)
    );

    // Next-state: clear has priority over insert.
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.sig = '0;
        end else if (ins_vld_i) begin
            state_d.sig = state_q.sig | ins_code;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign qry_and = state_q.sig & qry_code;
    assign and_o   = state_q.sig & opnd_i;
    assign or_o    = state_q.sig | opnd_i;

    addrsig_empty #(
        .CHUNK_W (CHUNK_W),
        .N_CHUNKS(N_CHUNKS)
    ) u_empty_sig (
        .sig_i  (state_q.sig),
        .empty_o(sig_empty_o)
    );

    addrsig_empty #(
        .CHUNK_W (CHUNK_W),
        .N_CHUNKS(N_CHUNKS)
    ) u_empty_qry (
        .sig_i  (qry_and),
        .empty_o(qry_empty)
    );

    addrsig_empty #(
        .CHUNK_W (CHUNK_W),
        .N_CHUNKS(N_CHUNKS)
    ) u_empty_and (
        .sig_i  (and_o),
        .empty_o(and_empty_o)
    );

    assign qry_hit_o  = ~qry_empty;
    assign sig_o      = state_q.sig;
    assign set_mask_o = state_q.sig[IDX_CHUNK*FIELD_W +: FIELD_W];
endmodule

// File: rtl/addrsig_chk.sv
`timescale 1ns/1ps
module addrsig_chk #(
    parameter int unsigned SIG_W   = 128,
    parameter int unsigned FIELD_W = 64
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               clr_i,
    input logic               ins_vld_i,
    input logic [SIG_W-1:0]   ins_code,
    input logic [SIG_W-1:0]   sig_o,
    input logic [FIELD_W-1:0] set_mask_o,
    input logic               sig_empty_o,
    input logic               qry_hit_o
);
    p_insert_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ins_vld_i && !clr_i) |=> ((sig_o & $past(ins_code)) == $past(ins_code)));

    p_no_loss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((sig_o & $past(sig_o)) == $past(sig_o)));

    p_hit_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        qry_hit_o |-> !sig_empty_o);

    p_mask_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sig_empty_o |-> (set_mask_o != '0));

    p_clear_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (sig_o == '0));

    p_clear_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && ins_vld_i) |=> sig_empty_o);

    p_idle_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !ins_vld_i) |=> $stable(sig_o));
endmodule

bind addrsig_unit addrsig_chk #(
    .SIG_W  (SIG_W),
    .FIELD_W(FIELD_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .ins_vld_i  (ins_vld_i),
    .ins_code   (ins_code),
    .sig_o      (sig_o),
    .set_mask_o (set_mask_o),
    .sig_empty_o(sig_empty_o),
    .qry_hit_o  (qry_hit_o)
);

// File: tb/tb_addrsig_unit.sv
`timescale 1ns/1ps
module tb_addrsig_unit;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned CHUNK_W  = 6;
    localparam int unsigned N_CHUNKS = 2;
    localparam int unsigned PERM_LO  = 6;
    localparam int unsigned PERM_HI  = 13;
    localparam int unsigned FIELD_W  = 1 << CHUNK_W;
    localparam int unsigned SIG_W    = N_CHUNKS * FIELD_W;
    localparam time CLK_PER = 5ns;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              clr_i = 1'b0;
    logic              ins_vld_i = 1'b0;
    logic [ADDR_W-1:0] ins_addr_i = '0;
    logic [ADDR_W-1:0] qry_addr_i = '0;
    logic [SIG_W-1:0]  opnd_i = '0;
    logic [SIG_W-1:0]  sig_o;
    logic [FIELD_W-1:0] set_mask_o;
    logic              sig_empty_o;
    logic              qry_hit_o;
    logic [SIG_W-1:0]  and_o;
    logic              and_empty_o;
    logic [SIG_W-1:0]  or_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [SIG_W-1:0]   sig_m = '0;
    logic [FIELD_W-1:0] mask_m = '0;

    always #(CLK_PER/2) clk = ~clk;

    addrsig_unit dut (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .clr_i      (clr_i),
        .ins_vld_i  (ins_vld_i),
        .ins_addr_i (ins_addr_i),
        .qry_addr_i (qry_addr_i),
        .opnd_i     (opnd_i),
        .sig_o      (sig_o),
        .set_mask_o (set_mask_o),
        .sig_empty_o(sig_empty_o),
        .qry_hit_o  (qry_hit_o),
        .and_o      (and_o),
        .and_empty_o(and_empty_o),
        .or_o       (or_o)
    );

    function automatic logic [SIG_W-1:0] enc(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] p;
        logic [SIG_W-1:0]  s;
        s = '0;
        for (int i = 0; i < ADDR_W; i++)
            p[i] = (i >= PERM_LO && i <= PERM_HI) ? a[PERM_LO + PERM_HI - i] : a[i];
        for (int k = 0; k < N_CHUNKS; k++)
            s[k*FIELD_W + int'(p[k*CHUNK_W +: CHUNK_W])] = 1'b1;
        return s;
    endfunction

    function automatic bit is_empty(input logic [SIG_W-1:0] s);
        for (int k = 0; k < N_CHUNKS; k++)
            if (s[k*FIELD_W +: FIELD_W] == '0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [SIG_W-1:0] act, input logic [SIG_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic insert(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        ins_vld_i  = 1'b1;
        ins_addr_i = a;
        @(negedge clk);
        ins_vld_i  = 1'b0;
        sig_m  = sig_m | enc(a);
        mask_m = mask_m | (FIELD_W'(1) << a[CHUNK_W-1:0]);
    endtask

    task automatic clear(input bit with_ins, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        clr_i      = 1'b1;
        ins_vld_i  = with_ins;
        ins_addr_i = a;
        @(negedge clk);
        clr_i     = 1'b0;
        ins_vld_i = 1'b0;
        sig_m  = '0;
        mask_m = '0;
    endtask

    task automatic query(input logic [ADDR_W-1:0] a, input string req);
        logic [SIG_W-1:0] c;
        qry_addr_i = a;
        #1;
        c = enc(a);
        check(qry_hit_o == ((sig_m & c) == c), req, SIG_W'(qry_hit_o), SIG_W'((sig_m & c) == c));
    endtask

    task automatic t_reset();
        check(sig_o == '0, "R1 sig", sig_o, '0);
        check(sig_empty_o == 1'b1, "R1 empty", SIG_W'(sig_empty_o), SIG_W'(1));
        check(set_mask_o == '0, "R1 mask", SIG_W'(set_mask_o), '0);
        query(16'h0000, "R1 hit");
    endtask

    task automatic t_perm();
        logic [SIG_W-1:0] e;
        insert(16'h1000);
        e = '0; e[0] = 1'b1; e[66] = 1'b1;
        check(sig_o == e, "R3 bit12 to chunk1 pos1", sig_o, e);
        clear(1'b0, '0);
        insert(16'h4000);
        e = '0; e[0] = 1'b1; e[64] = 1'b1;
        check(sig_o == e, "R3 bit14 unhashed", sig_o, e);
        clear(1'b0, '0);
        insert(16'h0040);
        check(sig_o == e, "R3 bit6 moved out", sig_o, e);
        clear(1'b0, '0);
    endtask

    task automatic t_insert();
        insert(16'h3A5C);
        check(sig_o == sig_m, "R2 single insert", sig_o, sig_m);
        check($countones(sig_o) == N_CHUNKS, "R2 one bit per field",
              SIG_W'($countones(sig_o)), SIG_W'(N_CHUNKS));
        check(sig_empty_o == 1'b0, "R5 nonempty", SIG_W'(sig_empty_o), '0);
    endtask

    task automatic t_accumulate();
        logic [SIG_W-1:0] prev;
        prev = sig_o;
        insert(16'h0123);
        insert(16'hBEEF);
        insert(16'h7001);
        check(sig_o == sig_m, "R4 accumulate", sig_o, sig_m);
        check((sig_o & prev) == prev, "R4 no bit lost", sig_o & prev, prev);
        query(16'hBEEF, "R6 member hit");
        query(16'h0002, "R6 non-member");
        query(16'h3A63, "R6 alias");
    endtask

    task automatic t_setops();
        logic [SIG_W-1:0] f0;
        @(negedge clk);
        opnd_i = enc(16'hBEEF) | enc(16'h5555);
        #1;
        check(and_o == (sig_m & opnd_i), "R7 and", and_o, sig_m & opnd_i);
        check(and_empty_o == is_empty(sig_m & opnd_i), "R7 and empty",
              SIG_W'(and_empty_o), SIG_W'(is_empty(sig_m & opnd_i)));
        check(or_o == (sig_m | opnd_i), "R8 or", or_o, sig_m | opnd_i);
        f0 = '0;
        f0[FIELD_W-1:0] = sig_m[FIELD_W-1:0];
        opnd_i = f0;
        #1;
        check(and_o != '0 && and_empty_o == 1'b1, "R5 one field zero",
              SIG_W'(and_empty_o), SIG_W'(1));
        opnd_i = '0;
        #1;
        check(or_o == sig_m, "R8 or zero operand", or_o, sig_m);
    endtask

    task automatic t_mask();
        check(set_mask_o == mask_m, "R9 set mask", SIG_W'(set_mask_o), SIG_W'(mask_m));
    endtask

    task automatic t_idle();
        logic [SIG_W-1:0] prev;
        prev = sig_o;
        ins_addr_i = 16'hFFFF;
        repeat (4) @(negedge clk);
        check(sig_o == prev, "R12 idle stable", sig_o, prev);
    endtask

    task automatic t_clear();
        clear(1'b0, '0);
        check(sig_o == '0, "R10 clear", sig_o, '0);
        check(sig_empty_o == 1'b1, "R10 empty after clear", SIG_W'(sig_empty_o), SIG_W'(1));
        insert(16'h2222);
        clear(1'b1, 16'h0F0F);
        check(sig_o == '0, "R11 clear beats insert", sig_o, '0);
        query(16'h0F0F, "R11 dropped address");
    endtask

    initial begin
        #(200000 * CLK_PER);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_perm();
        t_insert();
        t_accumulate();
        t_setops();
        t_mask();
        t_idle();
        t_clear();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule